// File: doc/BRIEF.md
# Dual-Clock Presettable Up/Down Counter

This block is a 4-bit counter with two count clock lines, one for each direction. It also has a 4-bit preset value with an active-low load, an active-high master clear, and two active-low terminal outputs (carry and borrow) that can drive the count lines of the next stage directly. A parameter picks decade counting (0 to 9) or binary counting (0 to 15).

Everything runs on a free-running system clock. The two count lines are treated as asynchronous inputs. Each passes through a two-flop synchroniser, and the counter acts on a detected low-to-high change of the synchronised line. To move the count, the opposite line is held high and the active line is pulsed low and then high again.

The carry output is low only while the count sits at its top code and the up line is low. The up line's return to high is therefore both the moment the count wraps and a rising edge on carry. Borrow behaves the same way at zero with the down line. For a multi-digit counter, wire carry to the next stage's up line and borrow to its down line.

Top module: `dual_clock_updn_counter`

## Requirements
- R1: While master_rst is high, count_out is 0 at once (asynchronously), whatever load_n, preset_in and the count lines do.
- R2: With master_rst low and load_n low, count_out equals preset_in from the first system clock edge on, for as long as load_n stays low; the count lines have no effect.
- R3: A rising edge on up_clk_in while dn_clk_in is high adds one to the count on the third system clock edge after the rise, and the top code (9 decade, 15 binary) wraps to 0.
- R4: A rising edge on dn_clk_in while up_clk_in is high subtracts one on the third system clock edge after the rise, and 0 wraps to the top code.
- R5: The count holds when a line rises while the other line is low, and when both lines rise in the same system clock cycle.
- R6: carry_n is 0 exactly when the count is the top code and the synchronised up line is low: it falls two system edges after up_clk_in falls and rises two edges after up_clk_in rises.
- R7: borrow_n is 0 exactly when the count is 0 and the synchronised down line is low, with the same two-edge timing relative to dn_clk_in.
- R8: In decade mode, a count of 10 to 15 goes to 0 on an up count and to 9 on a down count, and carry_n and borrow_n stay 1 while the count is in that range.
- R9: Two decade stages chained (carry_n to the next up_clk_in, borrow_n to the next dn_clk_in) count as one two-digit decimal counter in both directions.
- R10: Count edges that occur while master_rst is high or load_n is low are discarded, and none appears after the clear or load is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| master_rst | input | 1 | Active-high asynchronous clear to zero, highest priority |
| up_clk_in | input | 1 | Count-up line, acts on its rising edge |
| dn_clk_in | input | 1 | Count-down line, acts on its rising edge |
| load_n | input | 1 | Active-low level-sensitive preset load |
| preset_in | input | 4 | Value copied into the count during a load |
| count_out | output | 4 | Current count |
| carry_n | output | 1 | Active-low carry, low at top code while the up line is low |
| borrow_n | output | 1 | Active-low borrow, low at zero while the down line is low |

## Verification
The results fall due at fixed delays:
- A clear appears at once.
- A load shows one system clock edge after load_n falls.
- A count step lands on the third edge after its line rises.
- The terminal outputs follow their line two edges after each transition.
- In a chained pair, the upper digit moves five edges after the lower stage's line rises.

The bench drives inputs on falling clock edges and samples only after waiting at least one extra falling edge past each of these delays. It holds every line stable long enough that no later event can overlap the checked window. The terminal outputs are checked while a line is held low and again after it returns high. Discarded edges are checked by waiting for the synchroniser to settle before releasing the clear or load, and then checking the count.

// File: rtl/udc_pkg.sv
package udc_pkg;
  localparam int CW      = 4;
  localparam int DEC_TOP = 9;

  typedef logic [CW-1:0] cnt_t;

  // Highest legal code for the selected counting mode.
  function automatic cnt_t top_code(input bit decade);
    if (decade) return cnt_t'(DEC_TOP);
    return {CW{1'b1}};
  endfunction

  // Up step: the top code and any code above it go to zero.
  function automatic cnt_t step_up(input cnt_t v, input bit decade);
    if (v >= top_code(decade)) return '0;
    return v + cnt_t'(1);
  endfunction

  // Down step: zero and any code above the top go to the top code.
  function automatic cnt_t step_dn(input cnt_t v, input bit decade);
    if (v == '0 || v > top_code(decade)) return top_code(decade);
    return v - cnt_t'(1);
  endfunction
endpackage

// File: rtl/udc_edge_sync.sv
module udc_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic clr,
  input  logic line_in,
  output logic line_level,
  output logic line_rise
);
  localparam int TAPS = STAGES + 1;

  logic [TAPS-1:0] pipe_q;

  // The line idles high, so the pipe clears to ones: a clear raises no edge.
  always_ff @(posedge clk or posedge clr) begin
    if (clr) pipe_q <= '1;
    else     pipe_q <= {pipe_q[TAPS-2:0], line_in};
  end

  assign line_level = pipe_q[STAGES-1];
  assign line_rise  = pipe_q[STAGES-1] & ~pipe_q[STAGES];

  // R3
  rise_pulse_chk: assert property (@(posedge clk) disable iff (clr)
    line_rise |=> !line_rise);
endmodule

// File: rtl/udc_count_core.sv
module udc_count_core
  import udc_pkg::*;
#(
  parameter bit DECADE_MODE = 1'b1
) (
  input  logic clk,
  input  logic clr,
  input  logic load_n,
  input  cnt_t preset,
  input  logic up_level,
  input  logic up_rise,
  input  logic dn_level,
  input  logic dn_rise,
  output cnt_t count_q
);
  localparam cnt_t TOPV = top_code(DECADE_MODE);

  logic up_step;
  logic dn_step;

  // A step needs the opposite line high and no simultaneous rise on it.
  assign up_step = up_rise & dn_level & ~dn_rise;
  assign dn_step = dn_rise & up_level & ~up_rise;

  always_ff @(posedge clk or posedge clr) begin
    if (clr)          count_q <= '0;
    else if (!load_n) count_q <= preset;
    else if (up_step) count_q <= step_up(count_q, DECADE_MODE);
    else if (dn_step) count_q <= step_dn(count_q, DECADE_MODE);
  end

  // R2
  load_copy_chk: assert property (@(posedge clk) disable iff (clr)
    !load_n |=> count_q == $past(preset));
  // R3
  up_inc_chk: assert property (@(posedge clk) disable iff (clr)
    (up_step && load_n && count_q < TOPV) |=> count_q == $past(count_q) + cnt_t'(1));
  // R8
  up_wrap_chk: assert property (@(posedge clk) disable iff (clr)
    (up_step && load_n && count_q >= TOPV) |=> count_q == '0);
  // R4
  dn_dec_chk: assert property (@(posedge clk) disable iff (clr)
    (dn_step && load_n && count_q != '0 && count_q <= TOPV) |=> count_q == $past(count_q) - cnt_t'(1));
  // R8
  dn_wrap_chk: assert property (@(posedge clk) disable iff (clr)
    (dn_step && load_n && (count_q == '0 || count_q > TOPV)) |=> count_q == TOPV);
  // R5
  both_rise_hold_chk: assert property (@(posedge clk) disable iff (clr)
    (up_rise && dn_rise && load_n) |=> $stable(count_q));
  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (clr)
    (!up_step && !dn_step && load_n) |=> $stable(count_q));
endmodule

// File: rtl/udc_terminal.sv
module udc_terminal
  import udc_pkg::*;
#(
  parameter bit DECADE_MODE = 1'b1
) (
  input  cnt_t count_q,
  input  logic up_level,
  input  logic dn_level,
  output logic carry_n,
  output logic borrow_n
);
  localparam cnt_t TOPV = top_code(DECADE_MODE);

  // Both terms are flop outputs, so the chained clock is glitch free.
  assign carry_n  = ~((count_q == TOPV) & ~up_level);
  assign borrow_n = ~((count_q == '0)   & ~dn_level);
endmodule

// File: rtl/dual_clock_updn_counter.sv
module dual_clock_updn_counter
  import udc_pkg::*;
#(
  parameter bit DECADE_MODE = 1'b1,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          master_rst,
  input  logic          up_clk_in,
  input  logic          dn_clk_in,
  input  logic          load_n,
  input  logic [CW-1:0] preset_in,
  output logic [CW-1:0] count_out,
  output logic          carry_n,
  output logic          borrow_n
);
  localparam cnt_t TOPV   = top_code(DECADE_MODE);
  localparam int   NLINES = 2;

  logic [NLINES-1:0] line_raw;
  logic [NLINES-1:0] line_level;
  logic [NLINES-1:0] line_rise;
  cnt_t              count_q;

  // Index 0 is the up line, index 1 the down line.
  assign line_raw = {dn_clk_in, up_clk_in};

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    udc_edge_sync #(.STAGES(SYNC_STAGES)) sync_i (
      .clk        (clk),
      .clr        (master_rst),
      .line_in    (line_raw[g]),
      .line_level (line_level[g]),
      .line_rise  (line_rise[g])
    );
  end

  udc_count_core #(.DECADE_MODE(DECADE_MODE)) core_i (
    .clk      (clk),
    .clr      (master_rst),
    .load_n   (load_n),
    .preset   (preset_in),
    .up_level (line_level[0]),
    .up_rise  (line_rise[0]),
    .dn_level (line_level[1]),
    .dn_rise  (line_rise[1]),
    .count_q  (count_q)
  );

  udc_terminal #(.DECADE_MODE(DECADE_MODE)) term_i (
    .count_q  (count_q),
    .up_level (line_level[0]),
    .dn_level (line_level[1]),
    .carry_n  (carry_n),
    .borrow_n (borrow_n)
  );

  assign count_out = count_q;

  // R1
  clear_zero_chk: assert property (@(posedge clk)
    master_rst |-> count_out == '0);
  // R6
  carry_holds_top_chk: assert property (@(posedge clk) disable iff (master_rst)
    (!carry_n && load_n) |=> count_out == TOPV);
  // R7
  borrow_holds_zero_chk: assert property (@(posedge clk) disable iff (master_rst)
    (!borrow_n && load_n) |=> count_out == '0);
  // R8
  illegal_quiet_chk: assert property (@(posedge clk) disable iff (master_rst)
    (count_out > TOPV) |-> (carry_n && borrow_n));
endmodule

// File: tb/dual_clock_updn_counter_tb_top.sv
module dual_clock_updn_counter_tb_top;
  logic clk = 1'b0;
  logic mr, up, dn, ld_n;
  logic [3:0] pre;
  logic [3:0] d_cnt, b_cnt, c0_cnt, c1_cnt;
  logic d_cy, d_bw, b_cy, b_bw, c0_cy, c0_bw, c1_cy, c1_bw;
  logic c_up, c_dn;
  int n_chk = 0;
  int n_fail = 0;
  int exp_d, exp_b;

  always #10 clk = ~clk;

  dual_clock_updn_counter #(.DECADE_MODE(1'b1)) dut_i (
    .clk(clk), .master_rst(mr), .up_clk_in(up), .dn_clk_in(dn), .load_n(ld_n),
    .preset_in(pre), .count_out(d_cnt), .carry_n(d_cy), .borrow_n(d_bw));

  dual_clock_updn_counter #(.DECADE_MODE(1'b0)) bin_i (
    .clk(clk), .master_rst(mr), .up_clk_in(up), .dn_clk_in(dn), .load_n(ld_n),
    .preset_in(pre), .count_out(b_cnt), .carry_n(b_cy), .borrow_n(b_bw));

  dual_clock_updn_counter #(.DECADE_MODE(1'b1)) low_i (
    .clk(clk), .master_rst(mr), .up_clk_in(c_up), .dn_clk_in(c_dn), .load_n(1'b1),
    .preset_in(4'd0), .count_out(c0_cnt), .carry_n(c0_cy), .borrow_n(c0_bw));

  dual_clock_updn_counter #(.DECADE_MODE(1'b1)) high_i (
    .clk(clk), .master_rst(mr), .up_clk_in(c0_cy), .dn_clk_in(c0_bw), .load_n(1'b1),
    .preset_in(4'd0), .count_out(c1_cnt), .carry_n(c1_cy), .borrow_n(c1_bw));

  function automatic int ref_inc(input int v, input int top);
    return (v < top) ? v + 1 : 0;
  endfunction

  function automatic int ref_dec(input int v, input int top);
    if (v > top || v == 0) return top;
    return v - 1;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic check_counts(input string tag);
    chk({tag, " decade count"}, int'(d_cnt), exp_d);
    chk({tag, " binary count"}, int'(b_cnt), exp_b);
  endtask

  task automatic pulse_up();
    up = 1'b0;
    wait_n(3);
    chk("R6 decade carry while up low", int'(d_cy), (exp_d == 9) ? 0 : 1);
    chk("R6 binary carry while up low", int'(b_cy), (exp_b == 15) ? 0 : 1);
    chk("R7 borrow high while down high", int'(d_bw), 1);
    up = 1'b1;
    wait_n(4);
    exp_d = ref_inc(exp_d, 9);
    exp_b = ref_inc(exp_b, 15);
    check_counts("R3 up step");
    chk("R6 carry back high", int'(d_cy & b_cy), 1);
  endtask

  task automatic pulse_dn();
    dn = 1'b0;
    wait_n(3);
    chk("R7 decade borrow while down low", int'(d_bw), (exp_d == 0) ? 0 : 1);
    chk("R7 binary borrow while down low", int'(b_bw), (exp_b == 0) ? 0 : 1);
    chk("R6 carry high while up high", int'(d_cy), 1);
    dn = 1'b1;
    wait_n(4);
    exp_d = ref_dec(exp_d, 9);
    exp_b = ref_dec(exp_b, 15);
    check_counts("R4 down step");
    chk("R7 borrow back high", int'(d_bw & b_bw), 1);
  endtask

  task automatic pulse_both();
    up = 1'b0; dn = 1'b0;
    wait_n(3);
    up = 1'b1; dn = 1'b1;
    wait_n(4);
    check_counts("R5 simultaneous rise holds");
  endtask

  task automatic up_with_dn_low();
    dn = 1'b0;
    wait_n(3);
    chk("R7 borrow with down low", int'(d_bw), (exp_d == 0) ? 0 : 1);
    up = 1'b0;
    wait_n(3);
    up = 1'b1;
    wait_n(4);
    check_counts("R5 up rise with down low ignored");
    dn = 1'b1;
    wait_n(4);
    exp_d = ref_dec(exp_d, 9);
    exp_b = ref_dec(exp_b, 15);
    check_counts("R4 down rise with up high");
  endtask

  task automatic do_load(input int v);
    ld_n = 1'b0;
    pre = v[3:0];
    wait_n(2);
    exp_d = v; exp_b = v;
    check_counts("R2 load");
    if (v > 9) chk("R8 illegal code keeps terminals high", int'(d_cy & d_bw), 1);
    up = 1'b0;
    wait_n(3);
    up = 1'b1;
    wait_n(5);
    check_counts("R2 edge during load ignored");
    ld_n = 1'b1;
    wait_n(4);
    check_counts("R10 no edge after load release");
  endtask

  task automatic do_reset();
    mr = 1'b1;
    ld_n = 1'b0;
    pre = 4'd5;
    #1;
    chk("R1 clear is immediate", int'(d_cnt) + int'(b_cnt), 0);
    wait_n(2);
    chk("R1 clear beats load", int'(d_cnt) + int'(b_cnt), 0);
    up = 1'b0;
    wait_n(3);
    up = 1'b1;
    wait_n(5);
    ld_n = 1'b1;
    mr = 1'b0;
    wait_n(4);
    exp_d = 0; exp_b = 0;
    check_counts("R10 edge during clear discarded");
  endtask

  task automatic chain_step(input bit go_up, input int exp_val);
    if (go_up) c_up = 1'b0; else c_dn = 1'b0;
    wait_n(3);
    if (go_up) c_up = 1'b1; else c_dn = 1'b1;
    wait_n(8);
    chk("R9 chained value", int'(c1_cnt) * 10 + int'(c0_cnt), exp_val);
  endtask

  initial begin
    int r;
    int seed_dummy;
    mr = 1'b1; up = 1'b1; dn = 1'b1; ld_n = 1'b1; pre = 4'd0;
    c_up = 1'b1; c_dn = 1'b1;
    exp_d = 0; exp_b = 0;
    seed_dummy = $urandom(32'd20240613);
    wait_n(3);
    chk("R1 reset count", int'(d_cnt) + int'(b_cnt), 0);
    chk("R6 reset carry", int'(d_cy & b_cy), 1);
    chk("R7 reset borrow", int'(d_bw & b_bw), 1);
    mr = 1'b0;
    wait_n(2);

    // Directed walk: preset 7, up five times, down five times.
    do_load(7);
    for (int i = 0; i < 5; i++) pulse_up();
    for (int i = 0; i < 5; i++) pulse_dn();
    chk("R3 R4 walk returns to preset", exp_d, 7);
    // Binary wrap and decade illegal recovery.
    do_load(14);
    pulse_up();
    pulse_up();
    do_load(11);
    pulse_dn();
    do_load(15);
    pulse_up();
    do_load(0);
    pulse_dn();
    pulse_both();
    up_with_dn_low();
    do_reset();

    // Random mix.
    for (int k = 0; k < 120; k++) begin
      r = int'($urandom_range(0, 10));
      case (r)
        0, 1, 2, 3: pulse_up();
        4, 5, 6:    pulse_dn();
        7:          pulse_both();
        8:          do_load(int'($urandom_range(0, 15)));
        9:          up_with_dn_low();
        default:    if ((k % 4) == 0) do_reset(); else pulse_up();
      endcase
    end

    // Two chained decade stages.
    do_reset();
    for (int i = 1; i <= 25; i++) chain_step(1'b1, i);
    for (int i = 24; i >= 18; i--) chain_step(1'b0, i);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule